// File: doc/BRIEF.md
# Memory-Mapped I/O Address Decoder

This block sits between a processor's single load/store port, a data memory and two memory-mapped device holding registers. On every access it compares the address against two device addresses at the top of the address space. A store goes to exactly one destination: the memory write enable, the first device's enable or the second device's enable. A load is steered by a coded 2-bit read select that picks either the memory read data or one of the two holding registers and returns it to the processor.

The holding registers are part of the block. Each one captures the store data on the clock edge where its enable is high, and it drives its value out to the device it feeds. Memory data and store data pass between the processor and the memory outside this block. Only the memory write enable comes from here.

Top module: `mmio_glue`

## Requirements
- R1: With the default full-word decode, a store (`cpu_we`=1) to address 0xFFFFFFF4 raises `dev1_we` and leaves `mem_we` and `dev2_we` low in the same cycle.
- R2: A store to address 0xFFFFFFF8 raises `dev2_we` and leaves `mem_we` and `dev1_we` low in the same cycle.
- R3: For any address other than the two device addresses, including 0xFFFFFFF5 and the other neighbours, `mem_we` equals `cpu_we` and both device enables stay low.
- R4: When `cpu_we` is low, none of `mem_we`, `dev1_we` or `dev2_we` is high, whatever the address.
- R5: `rd_sel` depends on the address alone and is 2'b00 for memory, 2'b01 at 0xFFFFFFF4 and 2'b10 at 0xFFFFFFF8. It does not change with `cpu_we`.
- R6: `cpu_rdata` equals `mem_rdata` when `rd_sel` is 2'b00, `dev1_q` when it is 2'b01 and `dev2_q` when it is 2'b10, in the same cycle.
- R7: A device register takes `cpu_wdata` on the rising edge where its enable is high and keeps that value through every other cycle. The new value appears on `dev1_q`/`dev2_q` and on a load from that address after that edge.
- R8: While `rst_n` is low, both device registers read zero. Asserting reset after stores clears them again.
- R9: At most one of `mem_we`, `dev1_we`, `dev2_we` is high in any cycle.

Top module ports follow in list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 32 | Access address from the processor |
| cpu_we | input | 1 | Store strobe from the processor |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data returned to the processor |
| mem_rdata | input | 32 | Read data from the data memory |
| mem_we | output | 1 | Write enable to the data memory |
| dev1_we | output | 1 | Write enable of device register 1 |
| dev2_we | output | 1 | Write enable of device register 2 |
| rd_sel | output | 2 | Read select code (00 memory, 01 device 1, 10 device 2) |
| dev1_q | output | 32 | Held value of device register 1 |
| dev2_q | output | 32 | Held value of device register 2 |

## Verification
Enables, the read select and the load data are combinational, so they are due in the same cycle as the address. The bench drives each access just after a falling edge and samples one nanosecond later, before the next rising edge. Register contents are due only after the rising edge that closes a store. The bench updates its own model of both registers after that edge and checks the outputs and a read-back in the following cycle. The sweep covers both device addresses, their word and byte neighbours, and spread-out memory addresses, each with and without a store.

// File: rtl/mmio_glue_pkg.sv
package mmio_glue_pkg;
   typedef enum logic [1:0] {
      SEL_MEM  = 2'b00,
      SEL_DEV1 = 2'b01,
      SEL_DEV2 = 2'b10,
      SEL_NONE = 2'b11
   } rd_sel_t;

   localparam int unsigned NUM_DEV = 2;
endpackage

// File: rtl/mmio_addr_decode.sv
module mmio_addr_decode
   import mmio_glue_pkg::*;
#(
   parameter int unsigned             ADDR_W     = 32,
   parameter logic [ADDR_W-1:0]       DEV1_ADDR  = 32'hFFFF_FFF4,
   parameter logic [ADDR_W-1:0]       DEV2_ADDR  = 32'hFFFF_FFF8,
   parameter int unsigned             IGNORE_LSB = 0
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic               wr,
   output logic               mem_we,
   output logic [NUM_DEV-1:0] dev_we,
   output rd_sel_t            sel
);
   localparam int unsigned CMP_LO = IGNORE_LSB;

   logic hit1, hit2;

   generate
      if (IGNORE_LSB == 0) begin : g_full
         assign hit1 = (addr == DEV1_ADDR);
         assign hit2 = (addr == DEV2_ADDR);
      end else begin : g_partial
         assign hit1 = (addr[ADDR_W-1:CMP_LO] == DEV1_ADDR[ADDR_W-1:CMP_LO]);
         assign hit2 = (addr[ADDR_W-1:CMP_LO] == DEV2_ADDR[ADDR_W-1:CMP_LO]);
      end
   endgenerate

   always_comb begin
      if (hit1)      sel = SEL_DEV1;
      else if (hit2) sel = SEL_DEV2;
      else           sel = SEL_MEM;
   end

   always_comb begin
      dev_we[0] = wr & hit1;
      dev_we[1] = wr & hit2 & ~hit1;
      mem_we    = wr & ~hit1 & ~hit2;
   end
endmodule

// File: rtl/mmio_hold_reg.sv
module mmio_hold_reg #(
   parameter int unsigned      DATA_W = 32,
   parameter logic [DATA_W-1:0] RST_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST_VAL;
      else if (en) q <= d;
   end
endmodule

// File: rtl/mmio_rdata_mux.sv
module mmio_rdata_mux
   import mmio_glue_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  rd_sel_t                  sel,
   input  logic [DATA_W-1:0]        mem_data,
   input  logic [NUM_DEV-1:0][DATA_W-1:0] dev_data,
   output logic [DATA_W-1:0]        rdata
);
   always_comb begin
      unique case (sel)
         SEL_MEM:  rdata = mem_data;
         SEL_DEV1: rdata = dev_data[0];
         SEL_DEV2: rdata = dev_data[1];
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/mmio_glue.sv
module mmio_glue
   import mmio_glue_pkg::*;
#(
   parameter int unsigned       ADDR_W     = 32,
   parameter int unsigned       DATA_W     = 32,
   parameter logic [ADDR_W-1:0] DEV1_ADDR  = 32'hFFFF_FFF4,
   parameter logic [ADDR_W-1:0] DEV2_ADDR  = 32'hFFFF_FFF8,
   parameter int unsigned       IGNORE_LSB = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_we,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_we,
   output logic              dev1_we,
   output logic              dev2_we,
   output logic [1:0]        rd_sel,
   output logic [DATA_W-1:0] dev1_q,
   output logic [DATA_W-1:0] dev2_q
);
   generate
      if (IGNORE_LSB >= ADDR_W) begin : g_bad_lsb
         $error("IGNORE_LSB must be below ADDR_W");
      end
      if (ADDR_W < 2 || DATA_W < 1) begin : g_bad_width
         $error("ADDR_W and DATA_W too small");
      end
      if ((DEV1_ADDR >> IGNORE_LSB) == (DEV2_ADDR >> IGNORE_LSB)) begin : g_bad_map
         $error("device addresses overlap under the chosen decode");
      end
   endgenerate

   logic [NUM_DEV-1:0]             dev_we;
   logic [NUM_DEV-1:0][DATA_W-1:0] dev_q;
   rd_sel_t                        sel;

   mmio_addr_decode #(
      .ADDR_W    (ADDR_W),
      .DEV1_ADDR (DEV1_ADDR),
      .DEV2_ADDR (DEV2_ADDR),
      .IGNORE_LSB(IGNORE_LSB)
   ) u_dec (
      .addr   (cpu_addr),
      .wr     (cpu_we),
      .mem_we (mem_we),
      .dev_we (dev_we),
      .sel    (sel)
   );

   for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
      mmio_hold_reg #(.DATA_W(DATA_W)) u_reg (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (dev_we[i]),
         .d     (cpu_wdata),
         .q     (dev_q[i])
      );
   end

   mmio_rdata_mux #(.DATA_W(DATA_W)) u_mux (
      .sel      (sel),
      .mem_data (mem_rdata),
      .dev_data (dev_q),
      .rdata    (cpu_rdata)
   );

   assign dev1_we = dev_we[0];
   assign dev2_we = dev_we[1];
   assign rd_sel  = sel;
   assign dev1_q  = dev_q[0];
   assign dev2_q  = dev_q[1];
endmodule

// File: rtl/mmio_glue_checker.sv
module mmio_glue_checker #(
   parameter int unsigned       ADDR_W    = 32,
   parameter int unsigned       DATA_W    = 32,
   parameter logic [ADDR_W-1:0] DEV1_ADDR = 32'hFFFF_FFF4,
   parameter logic [ADDR_W-1:0] DEV2_ADDR = 32'hFFFF_FFF8,
   parameter int unsigned       IGNORE_LSB = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              cpu_we,
   input logic [DATA_W-1:0] cpu_wdata,
   input logic [DATA_W-1:0] cpu_rdata,
   input logic [DATA_W-1:0] mem_rdata,
   input logic              mem_we,
   input logic              dev1_we,
   input logic              dev2_we,
   input logic [1:0]        rd_sel,
   input logic [DATA_W-1:0] dev1_q,
   input logic [DATA_W-1:0] dev2_q
);
   logic exact;
   assign exact = (IGNORE_LSB == 0);

   // R1
   a_r1_dev1_store: assert property (@(posedge clk) disable iff (!rst_n)
      (exact && cpu_we && cpu_addr == DEV1_ADDR) |-> (dev1_we && !mem_we && !dev2_we));
   // R2
   a_r2_dev2_store: assert property (@(posedge clk) disable iff (!rst_n)
      (exact && cpu_we && cpu_addr == DEV2_ADDR) |-> (dev2_we && !mem_we && !dev1_we));
   // R3
   a_r3_mem_default: assert property (@(posedge clk) disable iff (!rst_n)
      (exact && cpu_addr != DEV1_ADDR && cpu_addr != DEV2_ADDR)
         |-> (mem_we == cpu_we && !dev1_we && !dev2_we));
   // R4
   a_r4_no_store_no_we: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_we |-> !(mem_we || dev1_we || dev2_we));
   // R6
   a_r6_mem_path: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel == 2'b00) |-> (cpu_rdata == mem_rdata));
   a_r6_dev1_path: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel == 2'b01) |-> (cpu_rdata == dev1_q));
   // R7
   a_r7_dev1_capture: assert property (@(posedge clk) disable iff (!rst_n)
      dev1_we |=> (dev1_q == $past(cpu_wdata)));
   a_r7_dev2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !dev2_we |=> $stable(dev2_q));
   // R9
   a_r9_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_we, dev1_we, dev2_we}));
endmodule

bind mmio_glue mmio_glue_checker #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .DEV1_ADDR (DEV1_ADDR),
   .DEV2_ADDR (DEV2_ADDR),
   .IGNORE_LSB(IGNORE_LSB)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_addr  (cpu_addr),
   .cpu_we    (cpu_we),
   .cpu_wdata (cpu_wdata),
   .cpu_rdata (cpu_rdata),
   .mem_rdata (mem_rdata),
   .mem_we    (mem_we),
   .dev1_we   (dev1_we),
   .dev2_we   (dev2_we),
   .rd_sel    (rd_sel),
   .dev1_q    (dev1_q),
   .dev2_q    (dev2_q)
);

// File: tb/mmio_glue_bench.sv
module mmio_glue_bench;
   localparam logic [31:0] A1 = 32'hFFFF_FFF4;
   localparam logic [31:0] A2 = 32'hFFFF_FFF8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cpu_addr = '0;
   logic        cpu_we = 1'b0;
   logic [31:0] cpu_wdata = '0;
   logic [31:0] cpu_rdata;
   logic [31:0] mem_rdata = '0;
   logic        mem_we, dev1_we, dev2_we;
   logic [1:0]  rd_sel;
   logic [31:0] dev1_q, dev2_q;

   int tests = 0;
   int fails = 0;
   logic [31:0] m1 = '0;
   logic [31:0] m2 = '0;
   logic [31:0] sweep [10];

   always #2 clk = ~clk;

   mmio_glue u_mmio_glue (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .mem_rdata(mem_rdata),
      .mem_we(mem_we), .dev1_we(dev1_we), .dev2_we(dev2_we), .rd_sel(rd_sel),
      .dev1_q(dev1_q), .dev2_q(dev2_q)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h (addr=%h we=%b)", req, act, exp, cpu_addr, cpu_we);
      end
   endtask

   // one access: drive after falling edge, check combinational results, then clock
   task automatic access(input logic [31:0] a, input logic w, input logic [31:0] wd,
                         input logic [31:0] md);
      logic h1, h2;
      logic [1:0] es;
      logic [31:0] er;
      @(negedge clk);
      cpu_addr = a; cpu_we = w; cpu_wdata = wd; mem_rdata = md;
      #1;
      h1 = (a == A1);
      h2 = (a == A2);
      es = h1 ? 2'b01 : (h2 ? 2'b10 : 2'b00);
      er = h1 ? m1 : (h2 ? m2 : md);
      chk("R1 dev1_we", {31'b0, dev1_we}, {31'b0, w & h1});
      chk("R2 dev2_we", {31'b0, dev2_we}, {31'b0, w & h2});
      if (!h1 && !h2) chk("R3 mem_we", {31'b0, mem_we}, {31'b0, w});
      else            chk("R1/R2 mem_we low", {31'b0, mem_we}, 32'b0);
      if (!w) chk("R4 no enable", {29'b0, mem_we, dev1_we, dev2_we}, 32'b0);
      chk("R5 rd_sel", {30'b0, rd_sel}, {30'b0, es});
      chk("R6 rdata", cpu_rdata, er);
      chk("R9 one enable", {31'b0, ($countones({mem_we, dev1_we, dev2_we}) > 1)}, 32'b0);
      @(posedge clk);
      #1;
      if (w && h1) m1 = wd;
      if (w && h2) m2 = wd;
      chk("R7 dev1_q", dev1_q, m1);
      chk("R7 dev2_q", dev2_q, m2);
   endtask

   initial begin
      #100000;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      sweep[0] = A1;            sweep[1] = A2;
      sweep[2] = 32'hFFFF_FFF0; sweep[3] = 32'hFFFF_FFFC;
      sweep[4] = 32'hFFFF_FFF5; sweep[5] = 32'hFFFF_FFF9;
      sweep[6] = 32'h0000_0000; sweep[7] = 32'h0000_0024;
      sweep[8] = 32'h7FFF_FFF4; sweep[9] = 32'hFFFF_FFF7;

      // R8: reset state
      #7;
      chk("R8 dev1_q in reset", dev1_q, 32'h0);
      chk("R8 dev2_q in reset", dev2_q, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R5 read select independent of store strobe; R1..R4, R6, R7, R9 sweep
      for (int pass = 0; pass < 3; pass++) begin
         for (int i = 0; i < 10; i++) begin
            for (int w = 0; w < 2; w++) begin
               access(sweep[i], w[0], 32'h1000_0000 * (pass + 1) + i * 16 + w,
                      32'hA5A5_0000 ^ (i * 257 + pass));
            end
         end
      end

      // R7: hold across memory traffic and read-back via loads
      access(A1, 1'b1, 32'd42, 32'h0);
      access(A2, 1'b1, 32'hDEAD_BEEF, 32'h0);
      for (int k = 0; k < 5; k++) access(32'h100 + k * 4, 1'b1, 32'hFFFF_FFFF, 32'h5555_0000 + k);
      access(A1, 1'b0, 32'h0, 32'h1234_5678);
      access(A2, 1'b0, 32'h0, 32'h1234_5678);

      // R8: reset after stores clears registers
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      m1 = '0; m2 = '0;
      chk("R8 dev1_q cleared", dev1_q, 32'h0);
      chk("R8 dev2_q cleared", dev2_q, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      access(A1, 1'b0, 32'h0, 32'h0);
      access(A2, 1'b0, 32'h0, 32'h0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule